// File: doc/BRIEF.md
# Boundary-Scan Chain for Bidirectional I/O Pins

This block is the serial test register that wraps a row of bidirectional user pins. Each pin owns a three-bit cell. The cell records what the core wants to drive (data and enable) and what the pad currently sees. The cells are strung into one chain, from a serial input to a serial output. An external test-access controller supplies the sequencing strobes: a step enable, a shift-or-capture select and an update strobe. An instruction decoder supplies a test-mode select.

Each cell has two register stages. The capture/shift stage either samples the three parallel values or moves the chain one place toward the serial output. The update stage copies the capture/shift stage on an update strobe and then holds that value. While test mode is off, the pins and the core see each other directly. While it is on, the update stage drives the pad data, the pad enable and the value the core reads as its input.

Top module: `bscan_chain`

## Requirements
- R1: After `rst_n` is asserted low, every capture/shift bit and every update bit reads zero. With `test_mode` high, all `pad_out`, `pad_oe` and `core_in` bits are 0, and `scan_out` is 0. Release of reset takes effect on the second `tck` rising edge after `rst_n` goes high.
- R2: On a `tck` rising edge with `scan_clk_en` high and `scan_shift` low, each pin's cell loads the values then present on `core_out`, `core_oe` and `pad_in`.
- R3: On a `tck` rising edge with `scan_clk_en` high and `scan_shift` high, the chain advances by one bit toward `scan_out`. The chain is 3×NUM_PINS bits long, so a bit presented on `scan_in` first shows on `scan_out` after exactly 3×NUM_PINS such edges.
- R4: On a `tck` rising edge with `scan_update` high, all update bits copy the capture/shift bits. Otherwise they keep their value, including while the chain shifts.
- R5: With `test_mode` low, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pad_in`, bit for bit.
- R6: With `test_mode` high, `pad_out`, `pad_oe` and `core_in` come from each pin's update bits for output, enable and input, whatever the core and pad values are.
- R7: Within a cell the bit order from `scan_in` toward `scan_out` is input, enable, output. Pin 0's cell is nearest `scan_in`, so after a capture the first bit on `scan_out` is the output bit of pin NUM_PINS-1.
- R8: On a `tck` edge with `scan_clk_en` low, the capture/shift bits neither capture nor shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_clk_en | input | 1 | Step enable for the capture/shift stage |
| scan_shift | input | 1 | 1 = shift, 0 = capture |
| scan_update | input | 1 | Update strobe |
| test_mode | input | 1 | 1 = pins driven from update stage |
| scan_in | input | 1 | Serial data into the chain |
| scan_out | output | 1 | Serial data out of the chain |
| core_out | input | NUM_PINS | Core-side output data |
| core_oe | input | NUM_PINS | Core-side output enable |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Data toward the pad drivers |
| pad_oe | output | NUM_PINS | Enable toward the pad drivers |
| core_in | output | NUM_PINS | Input value presented to the core |

## Verification
The hardest situation to reach is an update stage that holds a stable value while new, different data moves through the chain beneath it. To get there, the bench first shifts in one full pattern, strobes update and enables test mode. It then shifts in the complement without an update strobe and confirms that the pads have not moved. Bit placement is checked in both directions: shifted-in patterns are checked at the pads, and values captured from distinct core and pad patterns are checked as they shift out.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int unsigned CELL_BITS = 3;
  localparam int unsigned BIT_IN    = 0;
  localparam int unsigned BIT_EN    = 1;
  localparam int unsigned BIT_OUT   = 2;
  typedef logic [CELL_BITS-1:0] cell_t;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic shift_sel,
  input  logic upd_stb,
  input  logic tmode,
  input  logic ser_in,
  output logic ser_out,
  input  logic c_out,
  input  logic c_oe,
  input  logic p_in,
  output logic p_out,
  output logic p_oe,
  output logic c_in
);
  cell_t cap_q, cap_d;
  cell_t upd_q, upd_d;
  cell_t par_val;

  always_comb begin
    par_val          = '0;
    par_val[BIT_IN]  = p_in;
    par_val[BIT_EN]  = c_oe;
    par_val[BIT_OUT] = c_out;
  end

  always_comb begin
    cap_d = cap_q;
    if (step_en) begin
      if (shift_sel) cap_d = {cap_q[CELL_BITS-2:0], ser_in};
      else           cap_d = par_val;
    end
  end

  always_comb begin
    upd_d = upd_q;
    if (upd_stb) upd_d = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      upd_q <= '0;
    end else begin
      cap_q <= cap_d;
      upd_q <= upd_d;
    end
  end

  assign ser_out = cap_q[CELL_BITS-1];
  assign p_out   = tmode ? upd_q[BIT_OUT] : c_out;
  assign p_oe    = tmode ? upd_q[BIT_EN]  : c_oe;
  assign c_in    = tmode ? upd_q[BIT_IN]  : p_in;

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !shift_sel) |=> (cap_q[BIT_OUT] == $past(c_out) && cap_q[BIT_EN] == $past(c_oe) && cap_q[BIT_IN] == $past(p_in))); // R2
  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && shift_sel) |=> (cap_q[BIT_IN] == $past(ser_in) && ser_out == $past(cap_q[BIT_EN]))); // R3
  AST_UPDATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> $stable(upd_q)); // R4
  AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> upd_q == $past(cap_q)); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cap_q)); // R8
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                scan_clk_en,
  input  logic                scan_shift,
  input  logic                scan_update,
  input  logic                test_mode,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] core_in
);
  localparam int unsigned CHAIN_LEN = NUM_PINS * CELL_BITS;

  logic               rst_sync_n;
  logic [NUM_PINS:0]  link;

  bscan_rst_sync #(.STAGES(2)) u_rst (
    .clk        (tck),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign link[0] = scan_in;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cell
    bscan_cell u_cell (
      .clk       (tck),
      .rst_n     (rst_sync_n),
      .step_en   (scan_clk_en),
      .shift_sel (scan_shift),
      .upd_stb   (scan_update),
      .tmode     (test_mode),
      .ser_in    (link[p]),
      .ser_out   (link[p+1]),
      .c_out     (core_out[p]),
      .c_oe      (core_oe[p]),
      .p_in      (pad_in[p]),
      .p_out     (pad_out[p]),
      .p_oe      (pad_oe[p]),
      .c_in      (core_in[p])
    );
  end

  assign scan_out = link[NUM_PINS];

  AST_BYPASS_WHEN_OFF: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !test_mode |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in)); // R5
  AST_TEST_IGNORES_CORE: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (test_mode && $past(test_mode) && !$past(scan_update)) |-> $stable(pad_out) && $stable(pad_oe) && $stable(core_in)); // R6
  initial begin
    AST_CHAIN_LEN: assert (CHAIN_LEN == 3 * NUM_PINS); // R3
  end
endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int NP = 4;
  localparam int W  = 3 * NP;

  logic tck = 1'b0;
  logic rst_n, scan_clk_en, scan_shift, scan_update, test_mode, scan_in;
  logic scan_out;
  logic [NP-1:0] core_out, core_oe, pad_in, pad_out, pad_oe, core_in;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 tck = ~tck;

  bscan_chain #(.NUM_PINS(NP)) u0 (
    .tck(tck), .rst_n(rst_n), .scan_clk_en(scan_clk_en), .scan_shift(scan_shift),
    .scan_update(scan_update), .test_mode(test_mode), .scan_in(scan_in), .scan_out(scan_out),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic sh, input logic up, input logic si);
    scan_clk_en = en; scan_shift = sh; scan_update = up; scan_in = si;
    @(posedge tck); @(negedge tck);
    scan_clk_en = 0; scan_shift = 0; scan_update = 0; scan_in = 0;
  endtask

  task automatic shift_vec(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) step(1, 1, 0, v[i]);
  endtask

  task automatic read_chain(output logic [W-1:0] r);
    for (int i = 0; i < W; i++) begin
      r[W-1-i] = scan_out;
      step(1, 1, 0, 1'b0);
    end
  endtask

  function automatic logic [NP-1:0] pick(input logic [W-1:0] v, input int j);
    logic [NP-1:0] o;
    for (int p = 0; p < NP; p++) o[p] = v[3*p+j];
    return o;
  endfunction

  task automatic do_reset();
    rst_n = 0; scan_clk_en = 0; scan_shift = 0; scan_update = 0; scan_in = 0;
    repeat (2) @(negedge tck);
    rst_n = 1;
    repeat (3) @(negedge tck);
  endtask

  task automatic t_reset();
    logic [W-1:0] r;
    do_reset();
    test_mode = 1;
    core_out = '1; core_oe = '1; pad_in = '1;
    #0.5;
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 core_in", core_in, 0);
    chk("R1 scan_out", scan_out, 0);
    read_chain(r);
    chk("R1 chain", r, 0);
    test_mode = 0;
  endtask

  task automatic t_bypass();
    test_mode = 0;
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b1100; #0.5;
    chk("R5 pad_out", pad_out, 4'b1010);
    chk("R5 pad_oe", pad_oe, 4'b0110);
    chk("R5 core_in", core_in, 4'b1100);
    core_out = 4'b0101; core_oe = 4'b1001; pad_in = 4'b0011; #0.5;
    chk("R5 pad_out b", pad_out, 4'b0101);
    chk("R5 core_in b", core_in, 4'b0011);
  endtask

  task automatic t_length();
    logic [W-1:0] r;
    do_reset();
    step(1, 1, 0, 1'b1);
    for (int k = 1; k < W - 1; k++) step(1, 1, 0, 1'b0);
    chk("R3 not yet after 3N-1", scan_out, 0);
    step(1, 1, 0, 1'b0);
    chk("R3 out after 3N", scan_out, 1);
    read_chain(r);
    chk("R3 single one drains", r, {1'b1, {(W-1){1'b0}}});
  endtask

  task automatic t_load_update(input logic [W-1:0] v);
    logic [W-1:0] nv;
    nv = ~v;
    shift_vec(v);
    step(0, 0, 1, 1'b0);
    test_mode = 1;
    core_out = ~pick(v, 2); core_oe = ~pick(v, 1); pad_in = ~pick(v, 0); #0.5;
    chk("R6 R7 pad_out", pad_out, pick(v, 2));
    chk("R6 R7 pad_oe", pad_oe, pick(v, 1));
    chk("R6 R7 core_in", core_in, pick(v, 0));
    shift_vec(nv);
    chk("R4 hold out during shift", pad_out, pick(v, 2));
    chk("R4 hold oe during shift", pad_oe, pick(v, 1));
    chk("R4 hold in during shift", core_in, pick(v, 0));
    step(0, 0, 1, 1'b0);
    chk("R4 new update out", pad_out, pick(nv, 2));
    chk("R4 new update in", core_in, pick(nv, 0));
    test_mode = 0;
  endtask

  task automatic t_capture(input logic [NP-1:0] co, input logic [NP-1:0] ce, input logic [NP-1:0] pi);
    logic [W-1:0] r, e;
    for (int p = 0; p < NP; p++) begin
      e[3*p] = pi[p]; e[3*p+1] = ce[p]; e[3*p+2] = co[p];
    end
    core_out = co; core_oe = ce; pad_in = pi;
    step(1, 0, 0, 1'b0);
    chk("R7 first bit is last pin out", scan_out, co[NP-1]);
    core_out = ~co; core_oe = ~ce; pad_in = ~pi;
    read_chain(r);
    chk("R2 R7 captured chain", r, e);
  endtask

  task automatic t_idle();
    logic [W-1:0] r, e;
    core_out = 4'b0011; core_oe = 4'b0101; pad_in = 4'b1000;
    for (int p = 0; p < NP; p++) begin
      e[3*p] = pad_in[p]; e[3*p+1] = core_oe[p]; e[3*p+2] = core_out[p];
    end
    step(1, 0, 0, 1'b0);
    core_out = '1; core_oe = '0; pad_in = '1;
    step(0, 1, 0, 1'b1);
    step(0, 0, 0, 1'b1);
    step(0, 1, 0, 1'b1);
    chk("R8 scan_out frozen", scan_out, e[W-1]);
    read_chain(r);
    chk("R8 chain unchanged", r, e);
  endtask

  initial begin
    test_mode = 0; core_out = 0; core_oe = 0; pad_in = 0; rst_n = 1;
    scan_clk_en = 0; scan_shift = 0; scan_update = 0; scan_in = 0;
    @(negedge tck);
    t_reset();
    t_bypass();
    t_length();
    t_load_update(12'b1011_0010_1110);
    t_load_update(12'b0100_1101_0001);
    t_capture(4'b1001, 4'b0110, 4'b0011);
    t_capture(4'b0111, 4'b1000, 4'b1010);
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule